// File: doc/BRIEF.md
# Bus START/STOP Condition Sequencer

This block creates a START or a STOP condition on a two-wire serial bus (SCL clock, SDA data, both open drain), whatever levels the two lines have when it is asked to. It drives SDA low through a pull enable. It never drives SCL directly: it asks a separate clock generator for a falling or a rising SCL edge and watches the edge pulses that come back. Those pulses are a rising pulse, a falling pulse, and a falling pulse delayed until SCL is surely low.

A condition is an SDA edge while SCL is high. SDA falls for START and rises for STOP. Before that final edge, SDA must sit at the opposite, preparatory level: released (high) for START, pulled (low) for STOP. The sequencer checks the present levels and runs only the steps that are still needed. It can lower SCL, set SDA to the preparatory level, raise SCL, and then make the final SDA edge. A settle time of DELAY cycles follows every SDA change and every granted SCL rise. A bus monitor reports conditions it sees on the bus. If one appears before this block makes its own edge, the block flags it and gives up the attempt.

Top module: `bus_cond_gen`

## Requirements
- R1: After reset `sda_pull`, `req_scl_fall`, `req_scl_rise`, `done` and `early_cond` are all 0. SCL is taken as high, and not yet settled low.
- R2: The only change of `sda_pull` while SCL is high is the final edge. For START this is 0 to 1 (SDA falls). For STOP it is 1 to 0 (SDA rises). An abort is the one exception.
- R3: If SCL is high and SDA already has the preparatory level, no SCL request is made. The final SDA edge comes DELAY+1 cycles after the accepting clock edge. `done` comes DELAY+1 cycles after that.
- R4: If SDA has the wrong level and SCL is not settled low, `req_scl_fall` is held until the delayed falling pulse. `sda_pull` moves to the preparatory level on the edge that samples that pulse, never earlier.
- R5: After SDA reaches the preparatory level, the block waits DELAY+1 cycles. It then holds `req_scl_rise` until SCL is seen high. `req_scl_rise` is never asserted while SCL is known high.
- R6: The final SDA edge comes DELAY+2 cycles after the cycle in which the SCL rising pulse is applied.
- R7: Steps are skipped when the levels allow it. If SCL is settled low and SDA is wrong, SDA is set at once with no fall request. If SCL is low and SDA is already right, only a rise request is made.
- R8: The preparatory `sda_pull` is 0 for START and 1 for STOP. After a START completes, `sda_pull` stays 1. After a STOP completes, it stays 0.
- R9: `done` is a single-cycle pulse, one per completed condition.
- R10: A start or stop indication from the bus monitor before the final SDA edge raises `early_cond` for one cycle. It ends the attempt with `sda_pull` released and no `done`.
- R11: If `gen_start` and `gen_stop` arrive in the same cycle, a START is made.
- R12: Strobes that arrive while a sequence is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gen_start | input | 1 | One-cycle strobe: make a START |
| gen_stop | input | 1 | One-cycle strobe: make a STOP |
| sda_in | input | 1 | Present SDA line level |
| scl_rise | input | 1 | SCL rising-edge pulse |
| scl_fall | input | 1 | SCL falling-edge pulse |
| scl_fall_dly | input | 1 | Delayed SCL falling pulse (SCL surely low) |
| bus_start_seen | input | 1 | Bus monitor saw a START |
| bus_stop_seen | input | 1 | Bus monitor saw a STOP |
| sda_pull | output | 1 | 1 pulls SDA low |
| req_scl_fall | output | 1 | Ask the clock generator to lower SCL |
| req_scl_rise | output | 1 | Ask the clock generator to release SCL high |
| done | output | 1 | One-cycle pulse: condition made |
| early_cond | output | 1 | One-cycle pulse: another party made a condition first |

## Verification
The sequencer is tried from each starting level pair, and each pair should pick a different path:
- SCL high, SDA high: START with no SCL request, exact timing.
- SCL high, SDA held low: a STOP with no request, and a repeated START that needs both a fall and a rise.
- SCL settled low, SDA high: a STOP that sets SDA at once, and a START that only asks for a rise.

A model of the clock generator answers the requests. A line-level detector in the bench counts the real START and STOP events, so a wrong order of steps shows up as a stray or missing condition. Separate cases cover simultaneous strobes, strobes while busy, and an early bus condition that ends the attempt.

// File: rtl/bus_cond_pkg.sv
package bus_cond_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FALL,
        SQ_PREP,
        SQ_RISE,
        SQ_HIGH,
        SQ_FINAL
    } seq_state_t;

    typedef enum logic {
        COND_STOP  = 1'b0,
        COND_START = 1'b1
    } cond_kind_t;

    typedef struct packed {
        logic high;
        logic low_settled;
    } scl_view_t;

    // Line level SDA must hold just before the final edge
    function automatic logic prep_level(cond_kind_t k);
        return (k == COND_START);
    endfunction

    // Pull enable that produces the preparatory level
    function automatic logic prep_pull(cond_kind_t k);
        return (k == COND_STOP);
    endfunction

    // Pull enable after the final edge
    function automatic logic final_pull(cond_kind_t k);
        return (k == COND_START);
    endfunction

endpackage

// File: rtl/bus_cond_scl_track.sv
module bus_cond_scl_track
    import bus_cond_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_rise,
    input  logic      scl_fall,
    input  logic      scl_fall_dly,
    output scl_view_t scl
);

    logic high_q;
    logic settled_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            high_q    <= 1'b1;
            settled_q <= 1'b0;
        end else begin
            if (scl_rise)
                high_q <= 1'b1;
            else if (scl_fall)
                high_q <= 1'b0;

            if (scl_rise || scl_fall)
                settled_q <= 1'b0;
            else if (scl_fall_dly && !high_q)
                settled_q <= 1'b1;
        end
    end

    assign scl.high        = high_q;
    assign scl.low_settled = settled_q;

endmodule

// File: rtl/bus_cond_timer.sv
module bus_cond_timer #(
    parameter int DELAY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);

    localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CW'(DELAY);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/bus_cond_seq.sv
module bus_cond_seq
    import bus_cond_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      gen_start,
    input  logic      gen_stop,
    input  logic      sda_in,
    input  scl_view_t scl,
    input  logic      scl_rise,
    input  logic      scl_fall_dly,
    input  logic      cond_seen,
    input  logic      tmr_expired,
    output logic      tmr_load,
    output logic      sda_pull,
    output logic      req_fall,
    output logic      req_rise,
    output logic      done,
    output logic      early
);

    seq_state_t state_q, state_d;
    cond_kind_t kind_q, kind_d;
    logic       pull_q, pull_d;
    logic       done_q, done_d;
    logic       early_q, early_d;
    cond_kind_t new_kind;
    logic       pre_final;

    assign new_kind  = gen_start ? COND_START : COND_STOP;
    assign pre_final = (state_q == SQ_FALL) || (state_q == SQ_PREP) ||
                       (state_q == SQ_RISE) || (state_q == SQ_HIGH);

    always_comb begin
        state_d  = state_q;
        kind_d   = kind_q;
        pull_d   = pull_q;
        done_d   = 1'b0;
        early_d  = 1'b0;
        tmr_load = 1'b0;
        if (pre_final && cond_seen) begin
            pull_d  = 1'b0;
            early_d = 1'b1;
            state_d = SQ_IDLE;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (gen_start || gen_stop) begin
                        kind_d = new_kind;
                        if (sda_in != prep_level(new_kind)) begin
                            if (scl.low_settled) begin
                                pull_d   = prep_pull(new_kind);
                                tmr_load = 1'b1;
                                state_d  = SQ_PREP;
                            end else begin
                                state_d  = SQ_FALL;
                            end
                        end else begin
                            pull_d = prep_pull(new_kind);
                            if (scl.high) begin
                                tmr_load = 1'b1;
                                state_d  = SQ_HIGH;
                            end else begin
                                state_d  = SQ_RISE;
                            end
                        end
                    end
                end
                SQ_FALL: begin
                    if (scl_fall_dly || scl.low_settled) begin
                        pull_d   = prep_pull(kind_q);
                        tmr_load = 1'b1;
                        state_d  = SQ_PREP;
                    end
                end
                SQ_PREP: begin
                    if (tmr_expired)
                        state_d = SQ_RISE;
                end
                SQ_RISE: begin
                    if (scl_rise || scl.high) begin
                        tmr_load = 1'b1;
                        state_d  = SQ_HIGH;
                    end
                end
                SQ_HIGH: begin
                    if (tmr_expired) begin
                        pull_d   = final_pull(kind_q);
                        tmr_load = 1'b1;
                        state_d  = SQ_FINAL;
                    end
                end
                SQ_FINAL: begin
                    if (tmr_expired) begin
                        done_d  = 1'b1;
                        state_d = SQ_IDLE;
                    end
                end
                default: state_d = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            kind_q  <= COND_STOP;
            pull_q  <= 1'b0;
            done_q  <= 1'b0;
            early_q <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            pull_q  <= pull_d;
            done_q  <= done_d;
            early_q <= early_d;
        end
    end

    assign sda_pull = pull_q;
    assign req_fall = (state_q == SQ_FALL);
    assign req_rise = (state_q == SQ_RISE);
    assign done     = done_q;
    assign early    = early_q;

endmodule

// File: rtl/bus_cond_gen.sv
module bus_cond_gen
    import bus_cond_pkg::*;
#(
    parameter int DELAY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic gen_start,
    input  logic gen_stop,
    input  logic sda_in,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic scl_fall_dly,
    input  logic bus_start_seen,
    input  logic bus_stop_seen,
    output logic sda_pull,
    output logic req_scl_fall,
    output logic req_scl_rise,
    output logic done,
    output logic early_cond
);

    scl_view_t scl_v;
    logic      tmr_load;
    logic      tmr_expired;

    bus_cond_scl_track i_track (
        .clk          (clk),
        .rst          (rst),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .scl_fall_dly (scl_fall_dly),
        .scl          (scl_v)
    );

    bus_cond_timer #(.DELAY(DELAY)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    bus_cond_seq i_seq (
        .clk          (clk),
        .rst          (rst),
        .gen_start    (gen_start),
        .gen_stop     (gen_stop),
        .sda_in       (sda_in),
        .scl          (scl_v),
        .scl_rise     (scl_rise),
        .scl_fall_dly (scl_fall_dly),
        .cond_seen    (bus_start_seen || bus_stop_seen),
        .tmr_expired  (tmr_expired),
        .tmr_load     (tmr_load),
        .sda_pull     (sda_pull),
        .req_fall     (req_scl_fall),
        .req_rise     (req_scl_rise),
        .done         (done),
        .early        (early_cond)
    );

endmodule

// File: rtl/bus_cond_gen_chk.sv
module bus_cond_gen_chk (
    input logic clk,
    input logic rst,
    input logic gen_start,
    input logic gen_stop,
    input logic scl_rise,
    input logic scl_fall,
    input logic scl_fall_dly,
    input logic sda_pull,
    input logic req_scl_fall,
    input logic req_scl_rise,
    input logic done,
    input logic early_cond
);

    logic scl_hi_q;
    logic low_ok_q;
    logic pull_prev_q;
    logic busy_q;
    logic busy_prev_q;
    logic kind_start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_hi_q     <= 1'b1;
            low_ok_q     <= 1'b0;
            pull_prev_q  <= 1'b0;
            busy_q       <= 1'b0;
            busy_prev_q  <= 1'b0;
            kind_start_q <= 1'b0;
        end else begin
            if (scl_rise)
                scl_hi_q <= 1'b1;
            else if (scl_fall)
                scl_hi_q <= 1'b0;
            if (scl_rise || scl_fall)
                low_ok_q <= 1'b0;
            else if (scl_fall_dly)
                low_ok_q <= 1'b1;
            pull_prev_q <= sda_pull;
            busy_prev_q <= busy_q;
            if ((!busy_q || done || early_cond) && (gen_start || gen_stop)) begin
                busy_q       <= 1'b1;
                kind_start_q <= gen_start;
            end else if (done || early_cond) begin
                busy_q <= 1'b0;
            end
        end
    end

    // R2: while SCL is high, SDA moves only as the final edge
    assert_high_edge_final_R2: assert property (@(posedge clk) disable iff (rst)
        (scl_hi_q && busy_prev_q && (sda_pull != pull_prev_q) && !early_cond)
            |-> (sda_pull == kind_start_q));

    // R4: while SCL is low, SDA moves only once SCL has settled low
    assert_low_edge_settled_R4: assert property (@(posedge clk) disable iff (rst)
        (!scl_hi_q && (sda_pull != pull_prev_q) && !early_cond) |-> low_ok_q);

    // R4: a fall request is only made while SDA is still at the wrong level
    assert_fall_req_wrong_sda_R4: assert property (@(posedge clk) disable iff (rst)
        req_scl_fall |-> (sda_pull == kind_start_q));

    // R5: no rise request while SCL is already high
    assert_rise_req_scl_low_R5: assert property (@(posedge clk) disable iff (rst)
        req_scl_rise |-> !scl_hi_q);

    // R9: done is a one-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: an abort never reports completion
    assert_early_no_done_R10: assert property (@(posedge clk) disable iff (rst)
        early_cond |-> !done);

endmodule

bind bus_cond_gen bus_cond_gen_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .gen_start    (gen_start),
    .gen_stop     (gen_stop),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .scl_fall_dly (scl_fall_dly),
    .sda_pull     (sda_pull),
    .req_scl_fall (req_scl_fall),
    .req_scl_rise (req_scl_rise),
    .done         (done),
    .early_cond   (early_cond)
);

// File: tb/test_bus_cond_gen.sv
`timescale 1ns/1ps
module test_bus_cond_gen;

    localparam int D = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gen_start = 1'b0, gen_stop = 1'b0;
    logic scl_rise = 1'b0, scl_fall = 1'b0, scl_fall_dly = 1'b0;
    logic bus_start_seen = 1'b0, bus_stop_seen = 1'b0;
    logic sda_in;
    logic sda_pull, req_scl_fall, req_scl_rise, done, early_cond;

    logic scl_lvl = 1'b1;
    logic force_low = 1'b0;
    logic finished = 1'b0;

    int cyc = 0;
    int n_checks = 0, n_fail = 0;
    int n_done = 0, n_early = 0, n_fallreq = 0, n_risereq = 0;
    int n_start = 0, n_stop = 0;
    int pull_rise_cyc = -1, pull_fall_cyc = -1, risereq_cyc = -1, done_cyc = -1;
    int fall_cyc = -1, dly_cyc = -1, rise_cyc = -1;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign sda_in = ~sda_pull;

    bus_cond_gen #(.DELAY(D)) i_bus_cond_gen (
        .clk(clk), .rst(rst), .gen_start(gen_start), .gen_stop(gen_stop),
        .sda_in(sda_in), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .scl_fall_dly(scl_fall_dly), .bus_start_seen(bus_start_seen),
        .bus_stop_seen(bus_stop_seen), .sda_pull(sda_pull),
        .req_scl_fall(req_scl_fall), .req_scl_rise(req_scl_rise),
        .done(done), .early_cond(early_cond)
    );

    // Clock-generator model
    initial forever begin
        @(negedge clk);
        if ((req_scl_fall || force_low) && scl_lvl) begin
            @(negedge clk);
            fall_cyc = cyc; scl_fall = 1'b1; scl_lvl = 1'b0;
            @(negedge clk); scl_fall = 1'b0;
            @(negedge clk);
            dly_cyc = cyc; scl_fall_dly = 1'b1;
            @(negedge clk); scl_fall_dly = 1'b0;
        end else if (req_scl_rise && !scl_lvl) begin
            @(negedge clk);
            rise_cyc = cyc; scl_rise = 1'b1; scl_lvl = 1'b1;
            @(negedge clk); scl_rise = 1'b0;
        end
    end

    // Monitor and line-level condition detector
    initial begin
        logic pp = 1'b0, rp = 1'b0, sp = 1'b1, cp = 1'b1;
        forever begin
            @(posedge clk); #1;
            if (done) begin n_done++; done_cyc = cyc; end
            if (early_cond) n_early++;
            if (req_scl_fall) n_fallreq++;
            if (req_scl_rise) n_risereq++;
            if (req_scl_rise && !rp) risereq_cyc = cyc;
            if (sda_pull && !pp) pull_rise_cyc = cyc;
            if (!sda_pull && pp) pull_fall_cyc = cyc;
            if (scl_lvl && cp && sp && !sda_in) n_start++;
            if (scl_lvl && cp && !sp && sda_in) n_stop++;
            pp = sda_pull; rp = req_scl_rise; sp = sda_in; cp = scl_lvl;
        end
    end

    task automatic check_eq(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic request(bit st, bit sp, output int edge_cyc);
        @(negedge clk);
        gen_start = st; gen_stop = sp;
        edge_cyc = cyc + 1;
        @(negedge clk);
        gen_start = 1'b0; gen_stop = 1'b0;
    endtask

    task automatic wait_end();
        int d0 = n_done, e0 = n_early;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (n_done != d0 || n_early != e0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic lower_scl();
        force_low = 1'b1;
        for (int i = 0; i < 20 && scl_lvl; i++) @(negedge clk);
        force_low = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        check_eq("R1", "sda_pull", int'(sda_pull), 0);
        check_eq("R1", "req_fall", int'(req_scl_fall), 0);
        check_eq("R1", "req_rise", int'(req_scl_rise), 0);
        check_eq("R1", "done|early", int'(done | early_cond), 0);
    endtask

    task automatic t_start_idle();
        int e, fr = n_fallreq, rr = n_risereq, s0 = n_start, d0 = n_done;
        request(1, 0, e);
        wait_end();
        check_eq("R3", "no fall req", n_fallreq - fr, 0);
        check_eq("R3", "no rise req", n_risereq - rr, 0);
        check_eq("R3", "final edge cycle", pull_rise_cyc, e + D + 1);
        check_eq("R3", "done cycle", done_cyc, e + 2*D + 2);
        check_eq("R9", "done pulses", n_done - d0, 1);
        check_eq("R2", "START seen", n_start - s0, 1);
        check_eq("R8", "SDA held after START", int'(sda_pull), 1);
    endtask

    task automatic t_stop_ready();
        int e, fr = n_fallreq, rr = n_risereq, p0 = n_stop;
        request(0, 1, e);
        wait_end();
        check_eq("R3", "stop no req", n_fallreq - fr + n_risereq - rr, 0);
        check_eq("R3", "stop final edge", pull_fall_cyc, e + D + 1);
        check_eq("R2", "STOP seen", n_stop - p0, 1);
        check_eq("R8", "SDA released after STOP", int'(sda_pull), 0);
    endtask

    task automatic t_both();
        int e, s0 = n_start, p0 = n_stop;
        request(1, 1, e);
        wait_end();
        check_eq("R11", "start wins", n_start - s0, 1);
        check_eq("R11", "no stop", n_stop - p0, 0);
        check_eq("R11", "sda_pull", int'(sda_pull), 1);
    endtask

    task automatic t_repeated_start();
        int e, fr = n_fallreq, s0 = n_start, p0 = n_stop;
        request(1, 0, e);
        wait_end();
        check_eq("R4", "fall requested", int'(n_fallreq > fr), 1);
        check_eq("R4", "release after delayed fall", pull_fall_cyc, dly_cyc + 1);
        check_eq("R4", "held through fall pulse", int'(pull_fall_cyc > fall_cyc), 1);
        check_eq("R5", "rise request timing", risereq_cyc, pull_fall_cyc + D + 1);
        check_eq("R6", "final after rise", pull_rise_cyc, rise_cyc + D + 2);
        check_eq("R2", "one START", n_start - s0, 1);
        check_eq("R2", "no STOP", n_stop - p0, 0);
    endtask

    task automatic t_busy_ignored();
        int e, d0 = n_done, s0 = n_start, p0 = n_stop;
        request(0, 1, e);
        @(negedge clk); gen_start = 1'b1;
        @(negedge clk); gen_start = 1'b0;
        wait_end();
        repeat (3*D + 10) @(negedge clk);
        check_eq("R12", "single done", n_done - d0, 1);
        check_eq("R12", "no START", n_start - s0, 0);
        check_eq("R12", "STOP made", n_stop - p0, 1);
        check_eq("R12", "sda_pull", int'(sda_pull), 0);
    endtask

    task automatic t_stop_from_low();
        int e, fr, rr, p0, s0;
        lower_scl();
        fr = n_fallreq; rr = n_risereq; p0 = n_stop; s0 = n_start;
        request(0, 1, e);
        wait_end();
        check_eq("R7", "no fall req", n_fallreq - fr, 0);
        check_eq("R7", "prep at accept", pull_rise_cyc, e);
        check_eq("R5", "rise after prep", risereq_cyc, e + D + 1);
        check_eq("R7", "rise requested", int'(n_risereq > rr), 1);
        check_eq("R2", "STOP seen", n_stop - p0, 1);
        check_eq("R2", "no START", n_start - s0, 0);
        check_eq("R8", "released", int'(sda_pull), 0);
    endtask

    task automatic t_start_from_low();
        int e, fr, s0;
        lower_scl();
        fr = n_fallreq; s0 = n_start;
        request(1, 0, e);
        wait_end();
        check_eq("R7", "no fall req", n_fallreq - fr, 0);
        check_eq("R7", "rise req at once", risereq_cyc, e);
        check_eq("R6", "final after rise", pull_rise_cyc, rise_cyc + D + 2);
        check_eq("R2", "START seen", n_start - s0, 1);
    endtask

    task automatic t_early();
        int e, d0 = n_done, a0 = n_early;
        request(1, 0, e);
        bus_start_seen = 1'b1;
        @(negedge clk); bus_start_seen = 1'b0;
        repeat (4) @(negedge clk);
        check_eq("R10", "early pulses", n_early - a0, 1);
        check_eq("R10", "no done", n_done - d0, 0);
        check_eq("R10", "sda released", int'(sda_pull), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_start_idle();
        t_stop_ready();
        t_both();
        t_repeated_start();
        t_busy_ignored();
        t_stop_from_low();
        t_start_from_low();
        t_early();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule